// File: doc/BRIEF.md
# Byte ALU with Decimal Adjust and Skip Decision

This block is the arithmetic and logic unit of a small accumulator-based core. Each cycle it takes two byte operands, a 5-bit operation code and the current status flags. It returns a byte result, the next value of the four status flags, and a skip decision for the conditional-skip instructions. Fetching operands, choosing where the result is written and storing the status register all happen outside the block.

The operations cover binary add and subtract, each with and without carry. They also cover decimal adjust of a packed-BCD byte, the four bitwise operations, increment and decrement, and rotates with and without the carry flag. The skip family tests a byte for zero or non-zero, or steps it by one and tests the stepped value. Flags that an operation does not define pass through from `flag_in`, so the core can always write `flag_out` back.

The combinational datapath feeds a single output register. Results therefore appear one clock after the inputs are presented.

Top module: `alu8_core`

## Requirements
- R1: `result`, `flag_out` and `skip` are registered. They are all zero while `rst_n` is low at a rising edge. Otherwise they reflect the inputs sampled at the previous rising edge. Flag vector bits are: bit 0 carry (C), bit 1 half carry (AC), bit 2 zero (Z), bit 3 signed overflow (OV).
- R2: Code 0 (add) gives A+B and code 1 (add with carry) gives A+B+C_in. Both set C to the carry out of bit 7 and AC to the carry out of bit 3.
- R3: Code 2 (subtract) gives A-B and code 3 (subtract with borrow) gives A-B-(1-C_in). C is 1 exactly when no borrow occurs. AC is 1 exactly when the low-nibble difference needs no borrow.
- R4: For codes 0 to 3, OV is set when the true signed result falls outside -128..127.
- R5: Z equals (result == 00h) for codes 0 to 10. For codes 11 to 31, Z passes through from `flag_in`.
- R6: Code 4 (decimal adjust of A) first adds 06h when A's low nibble exceeds 9 or AC_in is set. It then adds 60h when the high nibble of that sum exceeds 9, that sum carried past bit 7, or C_in is set. C becomes 1 exactly when the 60h step applies. AC and OV pass through.
- R7: Codes 5, 6, 7 and 8 give A AND B, A OR B, A XOR B and NOT A. C, AC and OV pass through.
- R8: Code 9 gives A+1 and code 10 gives A-1, both modulo 256. C, AC and OV pass through.
- R9: Code 11 rotates A left and code 12 rotates A right, without carry. All four flags pass through.
- R10: Code 13 rotates A left through carry: bit 0 takes C_in and C takes A bit 7. Code 14 rotates A right through carry: bit 7 takes C_in and C takes A bit 0. AC, Z and OV pass through.
- R11: Code 15 sets skip when A is 00h and code 16 sets skip when A is not 00h. Both return A and leave all flags unchanged.
- R12: Code 17 returns A+1 and code 18 returns A-1, modulo 256. Skip is set when that value is 00h, and all flags pass through.
- R13: Skip is 0 for every code other than 15 to 18. Codes 19 to 31 return A with all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 8 | First operand (accumulator side) |
| op_b | input | 8 | Second operand |
| op_code | input | 5 | Operation select |
| flag_in | input | 4 | Current flags {OV, Z, AC, C} |
| result | output | 8 | Registered result byte |
| flag_out | output | 4 | Registered next flags {OV, Z, AC, C} |
| skip | output | 1 | Registered skip decision |

## Verification
The add and subtract paths are driven with operand pairs that cross the signed boundary (7Fh+01h, 80h-01h), which separates the overflow flag from the carry flag. Pairs that wrap to zero (FFh+01h, 05h-05h) separate carry and half carry from the zero flag. Decimal adjust is given bytes that need only the low correction, only the high one, both, or neither, and each of these is tried with and without incoming flags. Every other operation is run with all incoming flags set and then all clear, which shows whether a flag passes through or is recomputed. Thousands of random opcode, operand and flag combinations, including the unused codes, are compared against an independent model of the rules.

// File: rtl/alu8_pkg.sv
// Package: shared opcode encoding and flag bit positions for the byte ALU.
// Assumes every user of the ALU agrees on these codes; the core decodes them.
package alu8_pkg;

    localparam int BYTE_W = 8;
    localparam int OPC_W  = 5;
    localparam int FLG_W  = 4;

    // Flag vector bit positions
    localparam int FLG_C  = 0;
    localparam int FLG_AC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 5'd0,
        OP_ADC  = 5'd1,
        OP_SUB  = 5'd2,
        OP_SBC  = 5'd3,
        OP_DAA  = 5'd4,
        OP_AND  = 5'd5,
        OP_OR   = 5'd6,
        OP_XOR  = 5'd7,
        OP_CPL  = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_RL   = 5'd11,
        OP_RR   = 5'd12,
        OP_RLC  = 5'd13,
        OP_RRC  = 5'd14,
        OP_SZ   = 5'd15,
        OP_SNZ  = 5'd16,
        OP_SIZ  = 5'd17,
        OP_SDZ  = 5'd18
    } alu_op_e;

endpackage

// File: rtl/alu8_addsub.sv
// Module: two-stage nibble-split adder/subtractor.
// Computes a + b + cin, or a + ~b + cin when sub is high (two's complement
// subtract, carry out = no borrow). Reports the carry out of the lower half,
// the full carry out and signed overflow. Assumes W is even.
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_cout,
    output logic         ovf
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic [H:0]   lo_sum;
    logic [W-H:0] hi_sum;

    // Invert the second operand for subtraction
    always_comb b_eff = sub ? ~b : b;

    // Lower half first, its carry feeds the upper half
    always_comb begin
        lo_sum = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, cin};
        hi_sum = {1'b0, a[W-1:H]} + {1'b0, b_eff[W-1:H]} + {{(W-H){1'b0}}, lo_sum[H]};
    end

    // Assemble outputs and derive overflow from operand and result signs
    always_comb begin
        sum       = {hi_sum[W-H-1:0], lo_sum[H-1:0]};
        cout      = hi_sum[W-H];
        half_cout = lo_sum[H];
        ovf       = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu8_decadj.sv
// Module: packed-BCD decimal adjust of one byte.
// Low step adds 06h when the low digit is above 9 or the half carry is set;
// high step adds 60h when the intermediate high digit is above 9, the low
// step carried out, or the carry is set. Assumes an 8-bit operand.
module alu8_decadj (
    input  logic [7:0] a,
    input  logic       c_in,
    input  logic       ac_in,
    output logic [7:0] res,
    output logic       c_out
);
    logic       lo_fix;
    logic       hi_fix;
    logic [8:0] mid;

    // Low digit correction
    always_comb begin
        lo_fix = (a[3:0] > 4'd9) || ac_in;
        mid    = {1'b0, a} + (lo_fix ? 9'h006 : 9'h000);
    end

    // High digit correction and carry
    always_comb begin
        hi_fix = (mid[7:4] > 4'd9) || mid[8] || c_in;
        res    = mid[7:0] + (hi_fix ? 8'h60 : 8'h00);
        c_out  = hi_fix;
    end

endmodule

// File: rtl/alu8_bitops.sv
// Module: bitwise operations and rotates.
// Handles AND/OR/XOR/complement and the four rotates; carry out is the
// shifted-out bit for rotate-through-carry and the incoming carry otherwise.
// Assumes op is one of the package codes; others return a unchanged.
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out
);
    // Select the bitwise or rotate result
    always_comb begin
        res   = a;
        c_out = c_in;
        unique case (op)
            OP_AND: res = a & b;
            OP_OR:  res = a | b;
            OP_XOR: res = a ^ b;
            OP_CPL: res = ~a;
            OP_RL:  res = {a[W-2:0], a[W-1]};
            OP_RR:  res = {a[0], a[W-1:1]};
            OP_RLC: begin
                res   = {a[W-2:0], c_in};
                c_out = a[W-1];
            end
            OP_RRC: begin
                res   = {c_in, a[W-1:1]};
                c_out = a[0];
            end
            default: res = a;
        endcase
    end

endmodule

// File: rtl/alu8_core.sv
// Module: byte ALU top. Decodes the operation, selects among the adder,
// decimal adjust and bit-operation units, builds the next flags and the
// skip decision, and registers all outputs (one cycle latency).
// Assumes synchronous active-low reset; flags not defined by an op pass through.
module alu8_core
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] op_a,
    input  logic [BYTE_W-1:0] op_b,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [FLG_W-1:0]  flag_in,
    output logic [BYTE_W-1:0] result,
    output logic [FLG_W-1:0]  flag_out,
    output logic              skip
);
    alu_op_e           op;
    logic              is_sub;
    logic              add_cin;
    logic [BYTE_W-1:0] add_sum;
    logic              add_c;
    logic              add_ac;
    logic              add_ov;
    logic [BYTE_W-1:0] daa_res;
    logic              daa_c;
    logic [BYTE_W-1:0] bit_res;
    logic              bit_c;
    logic [BYTE_W-1:0] step_res;
    logic [BYTE_W-1:0] nxt_res;
    logic [FLG_W-1:0]  nxt_flg;
    logic              nxt_skip;

    // Decode the opcode and adder controls
    always_comb begin
        op      = alu_op_e'(op_code);
        is_sub  = (op == OP_SUB) || (op == OP_SBC);
        add_cin = (op == OP_SUB) ? 1'b1 :
                  ((op == OP_ADC) || (op == OP_SBC)) ? flag_in[FLG_C] : 1'b0;
    end

    alu8_addsub #(.W(BYTE_W)) u_add (
        .a         (op_a),
        .b         (op_b),
        .cin       (add_cin),
        .sub       (is_sub),
        .sum       (add_sum),
        .cout      (add_c),
        .half_cout (add_ac),
        .ovf       (add_ov)
    );

    alu8_decadj u_daa (
        .a     (op_a),
        .c_in  (flag_in[FLG_C]),
        .ac_in (flag_in[FLG_AC]),
        .res   (daa_res),
        .c_out (daa_c)
    );

    alu8_bitops #(.W(BYTE_W)) u_bit (
        .a     (op_a),
        .b     (op_b),
        .op    (op),
        .c_in  (flag_in[FLG_C]),
        .res   (bit_res),
        .c_out (bit_c)
    );

    // Step by one for increment/decrement and their skip variants
    always_comb
        step_res = op_a + (((op == OP_DEC) || (op == OP_SDZ)) ?
                           {BYTE_W{1'b1}} : {{(BYTE_W-1){1'b0}}, 1'b1});

    // Select the result, next flags and skip decision
    always_comb begin
        nxt_res  = op_a;
        nxt_flg  = flag_in;
        nxt_skip = 1'b0;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                nxt_res         = add_sum;
                nxt_flg[FLG_C]  = add_c;
                nxt_flg[FLG_AC] = add_ac;
                nxt_flg[FLG_OV] = add_ov;
                nxt_flg[FLG_Z]  = (add_sum == '0);
            end
            OP_DAA: begin
                nxt_res        = daa_res;
                nxt_flg[FLG_C] = daa_c;
                nxt_flg[FLG_Z] = (daa_res == '0);
            end
            OP_AND, OP_OR, OP_XOR, OP_CPL: begin
                nxt_res        = bit_res;
                nxt_flg[FLG_Z] = (bit_res == '0);
            end
            OP_INC, OP_DEC: begin
                nxt_res        = step_res;
                nxt_flg[FLG_Z] = (step_res == '0);
            end
            OP_RL, OP_RR: nxt_res = bit_res;
            OP_RLC, OP_RRC: begin
                nxt_res        = bit_res;
                nxt_flg[FLG_C] = bit_c;
            end
            OP_SZ:  nxt_skip = (op_a == '0);
            OP_SNZ: nxt_skip = (op_a != '0);
            OP_SIZ, OP_SDZ: begin
                nxt_res  = step_res;
                nxt_skip = (step_res == '0);
            end
            default: nxt_res = op_a;
        endcase
    end

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            flag_out <= '0;
            skip     <= 1'b0;
        end else begin
            result   <= nxt_res;
            flag_out <= nxt_flg;
            skip     <= nxt_skip;
        end
    end

endmodule

// File: rtl/alu8_core_chk.sv
// Module: assertion checker for alu8_core, attached by bind.
// Relates registered outputs to the inputs sampled one edge earlier.
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] op_a,
    input logic [OPC_W-1:0]  op_code,
    input logic [FLG_W-1:0]  flag_in,
    input logic [BYTE_W-1:0] result,
    input logic [FLG_W-1:0]  flag_out,
    input logic              skip
);
    logic up_valid;

    // Tracks that the previous edge was out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) up_valid <= 1'b0;
        else        up_valid <= 1'b1;
    end

    // R5: zero flag follows the result for the flag-updating codes
    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(op_code) <= 5'd10) |-> (flag_out[FLG_Z] == (result == 8'h00)));

    // R7: bitwise ops keep carry, half carry and overflow
    assert_logic_keeps_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(op_code) >= 5'd5 && $past(op_code) <= 5'd8) |->
        (flag_out[FLG_C] == $past(flag_in[FLG_C]) && flag_out[FLG_AC] == $past(flag_in[FLG_AC])
         && flag_out[FLG_OV] == $past(flag_in[FLG_OV])));

    // R9: plain rotate left
    assert_rotate_left_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(op_code) == 5'd11) |->
        (result == {$past(op_a[6:0]), $past(op_a[7])} && flag_out == $past(flag_in)));

    // R10: rotate right through carry
    assert_rotate_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(op_code) == 5'd14) |->
        (result == {$past(flag_in[FLG_C]), $past(op_a[7:1])} && flag_out[FLG_C] == $past(op_a[0])));

    // R11: skip-if-zero decision
    assert_skip_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && $past(op_code) == 5'd15) |-> (skip == ($past(op_a) == 8'h00)));

    // R13: no skip outside the skip family
    assert_no_skip_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && ($past(op_code) < 5'd15 || $past(op_code) > 5'd18)) |-> !skip);

endmodule

bind alu8_core alu8_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_code  (op_code),
    .flag_in  (flag_in),
    .result   (result),
    .flag_out (flag_out),
    .skip     (skip)
);

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op_a = '0;
    logic [7:0] op_b = '0;
    logic [4:0] op_code = '0;
    logic [3:0] flag_in = '0;
    logic [7:0] result;
    logic [3:0] flag_out;
    logic       skip;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    alu8_core u0 (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_code(op_code),
        .flag_in(flag_in), .result(result), .flag_out(flag_out), .skip(skip)
    );

    function automatic int sgn(input logic [7:0] v);
        return (v > 8'd127) ? int'(v) - 256 : int'(v);
    endfunction

    // Reference model: returns {skip, flags[3:0] = OV,Z,AC,C, result[7:0]}
    function automatic logic [12:0] model(input logic [4:0] op, input logic [7:0] a,
                                          input logic [7:0] b, input logic [3:0] f);
        int r; int cin; int ssum; int lo; int t; int adj;
        logic [7:0] res = a;
        logic c = f[0], ac = f[1], z = f[2], ov = f[3], sk = 1'b0;
        case (op)
            5'd0, 5'd1: begin
                cin  = (op == 5'd1) ? int'(f[0]) : 0;
                r    = int'(a) + int'(b) + cin;
                res  = r[7:0]; c = (r > 255);
                ac   = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
                ssum = sgn(a) + sgn(b) + cin; ov = (ssum > 127) || (ssum < -128);
                z    = (res == 0);
            end
            5'd2, 5'd3: begin
                cin  = (op == 5'd2) ? 0 : 1 - int'(f[0]);
                r    = int'(a) - int'(b) - cin;
                res  = r[7:0]; c = (r >= 0);
                ac   = ((int'(a) % 16) - (int'(b) % 16) - cin) >= 0;
                ssum = sgn(a) - sgn(b) - cin; ov = (ssum > 127) || (ssum < -128);
                z    = (res == 0);
            end
            5'd4: begin
                lo  = int'(a) % 16;
                adj = (lo > 9 || f[1]) ? 6 : 0;
                t   = int'(a) + adj;
                c   = (((t / 16) % 16) > 9) || (t > 255) || f[0];
                t   = t + (c ? 96 : 0);
                res = t[7:0]; z = (res == 0);
            end
            5'd5: begin res = a & b; z = (res == 0); end
            5'd6: begin res = a | b; z = (res == 0); end
            5'd7: begin res = a ^ b; z = (res == 0); end
            5'd8: begin res = ~a;    z = (res == 0); end
            5'd9:  begin r = (int'(a) + 1) % 256; res = r[7:0]; z = (res == 0); end
            5'd10: begin r = (int'(a) + 255) % 256; res = r[7:0]; z = (res == 0); end
            5'd11: begin r = (int'(a) * 2) % 256 + int'(a) / 128; res = r[7:0]; end
            5'd12: begin r = int'(a) / 2 + (int'(a) % 2) * 128; res = r[7:0]; end
            5'd13: begin r = (int'(a) * 2) % 256 + int'(f[0]); res = r[7:0]; c = a[7]; end
            5'd14: begin r = int'(a) / 2 + int'(f[0]) * 128; res = r[7:0]; c = a[0]; end
            5'd15: sk = (a == 0);
            5'd16: sk = (a != 0);
            5'd17: begin r = (int'(a) + 1) % 256; res = r[7:0]; sk = (res == 0); end
            5'd18: begin r = (int'(a) + 255) % 256; res = r[7:0]; sk = (res == 0); end
            default: res = a;
        endcase
        return {sk, ov, z, ac, c, res};
    endfunction

    function automatic string tag_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1: return "R2";
            5'd2, 5'd3: return "R3";
            5'd4: return "R6";
            5'd5, 5'd6, 5'd7, 5'd8: return "R7";
            5'd9, 5'd10: return "R8";
            5'd11, 5'd12: return "R9";
            5'd13, 5'd14: return "R10";
            5'd15, 5'd16: return "R11";
            5'd17, 5'd18: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input logic [12:0] got, input logic [12:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got skip=%b flags=%b res=%h, expected skip=%b flags=%b res=%h",
                     tag, got[12], got[11:8], got[7:0], exp[12], exp[11:8], exp[7:0]);
        end
    endtask

    // Drive at falling edge, sample 1 ns after the capturing rising edge
    task automatic run(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic [3:0] f, input string tag);
        @(negedge clk);
        op_code = op; op_a = a; op_b = b; flag_in = f;
        @(posedge clk);
        #1;
        check(tag, {skip, flag_out, result}, model(op, a, b, f));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        op_a = 8'hA5; op_b = 8'h5A; op_code = 5'd0; flag_in = 4'hF;
        repeat (3) @(posedge clk);
        #1;
        check("R1", {skip, flag_out, result}, 13'd0);  // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;
        // R1: latency, output changes only at the edge after inputs apply
        run(5'd0, 8'h12, 8'h34, 4'h0, "R1");
        // R2 / R4 directed
        run(5'd0, 8'h7F, 8'h01, 4'h0, "R4");
        run(5'd0, 8'hFF, 8'h01, 4'h0, "R2");
        run(5'd1, 8'h0F, 8'h00, 4'h1, "R2");
        run(5'd1, 8'h80, 8'h80, 4'h0, "R4");
        // R3 directed
        run(5'd2, 8'h05, 8'h05, 4'h0, "R3");
        run(5'd2, 8'h03, 8'h05, 4'h1, "R3");
        run(5'd3, 8'h10, 8'h01, 4'h0, "R3");
        run(5'd3, 8'h10, 8'h10, 4'h1, "R5");
        run(5'd2, 8'h80, 8'h01, 4'h0, "R4");
        // R6 directed: none, low only, high only, both
        run(5'd4, 8'h45, 8'h00, 4'h0, "R6");
        run(5'd4, 8'h4B, 8'h00, 4'h0, "R6");
        run(5'd4, 8'h15, 8'h00, 4'h2, "R6");
        run(5'd4, 8'hA3, 8'h00, 4'h0, "R6");
        run(5'd4, 8'h9A, 8'h00, 4'h0, "R6");
        run(5'd4, 8'h22, 8'h00, 4'h1, "R6");
        // R7 / R8 with all flags set
        run(5'd5, 8'hF0, 8'h0F, 4'hF, "R7");
        run(5'd8, 8'hFF, 8'h00, 4'hB, "R7");
        run(5'd9, 8'hFF, 8'h00, 4'hB, "R8");
        run(5'd10, 8'h00, 8'h00, 4'h0, "R8");
        // R9 / R10
        run(5'd11, 8'h81, 8'h00, 4'hF, "R9");
        run(5'd12, 8'h01, 8'h00, 4'h0, "R9");
        run(5'd13, 8'h80, 8'h00, 4'h0, "R10");
        run(5'd14, 8'h01, 8'h00, 4'h1, "R10");
        // R11 / R12 / R13
        run(5'd15, 8'h00, 8'h00, 4'h5, "R11");
        run(5'd16, 8'h00, 8'h00, 4'hA, "R11");
        run(5'd17, 8'hFF, 8'h00, 4'h0, "R12");
        run(5'd18, 8'h01, 8'h00, 4'hF, "R12");
        run(5'd18, 8'h00, 8'h00, 4'h0, "R12");
        run(5'd25, 8'h3C, 8'hFF, 4'h9, "R13");
        // Random mix over all codes
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] op_r;
            op_r = 5'($urandom_range(0, 31));
            run(op_r, 8'($urandom), 8'($urandom), 4'($urandom), tag_of(op_r));
        end
        // R1: reset again clears registered outputs
        @(negedge clk);
        rst_n = 1'b0; op_code = 5'd16; op_a = 8'h77; flag_in = 4'hF;
        @(posedge clk);
        #1;
        check("R1", {skip, flag_out, result}, 13'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

endmodule